// File: doc/BRIEF.md
# Table-Paged Register Address Mapper

This block sits between the byte-oriented front end of a two-wire slave and a flat backing store that holds more bytes than an 8-bit address can reach. The lower half of the main device's address space (00h to 7Eh) always lands on one fixed page of the store. Byte 7Fh is the page-select register, which lives inside this block. The upper half (80h to FFh) is a window whose contents are picked by that register. The auxiliary device select reaches only its own flat 128-byte memory and never the window.

Table numbers 00h, 01h, 03h, 04h and 05h each own a page of the store: two customer data pages, a configuration page and two resistor look-up pages. Table 02h is an alias. When the auxiliary-mapping enable input is high, the main window shows the auxiliary device's memory. When the enable is low, table 02h does not exist. Any access to a location that does not exist raises a flag, leaves the store untouched and reads back as FFh. The current table number is driven out so that a permission checker can use it.

The store is expected to have a registered read port. Read data therefore returns one cycle after the read strobe, together with a valid pulse.

Top module: `table_pager`

## Requirements
- R1: After reset the table register holds 00h, `table_num` shows 00h, and `no_loc` is low while no strobe is active.
- R2: A main-device access to 00h–7Eh drives `mem_addr = {3'd6, addr[6:0]}` whatever the selected table, and asserts `mem_rd`/`mem_wr` with the strobe.
- R3: A main-device write to 7Fh loads `wr_data` into the table register, so that `table_num` changes after the next clock edge. It asserts no `mem_wr`. A main-device read of 7Fh returns the register value on `rd_data`.
- R4: A main-device access to 80h–FFh with table 00h, 01h, 03h, 04h or 05h drives `mem_addr = {table[2:0], addr[6:0]}`. Different tables therefore keep separate contents.
- R5: With table 02h and `aux_map_en` = 1, a main-device access to 80h–FFh drives `mem_addr = {3'd7, addr[6:0]}`, the page of the auxiliary memory.
- R6: With table 02h and `aux_map_en` = 0, or with any table value above 05h, a main-device access to 80h–FFh raises `no_loc` in the same cycle. It asserts neither `mem_rd` nor `mem_wr`, and a read returns FFh.
- R7: An auxiliary-device access to 00h–7Fh drives `mem_addr = {3'd7, addr[6:0]}` and leaves the table register unchanged, even at 7Fh. An auxiliary-device access to 80h–FFh behaves like R6.
- R8: Every read, with `rd_en` = 1 and `wr_en` = 0, raises `rd_valid` exactly one cycle later with the returned byte on `rd_data`. `rd_valid` is low in every other cycle.
- R9: When `rd_en` and `wr_en` are both high, the access is a write only: `mem_rd` stays low and no `rd_valid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_aux | input | 1 | Device select: 0 = main device, 1 = auxiliary device |
| addr | input | 8 | Byte address from the front end |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | 8 | Write data |
| aux_map_en | input | 1 | Shows the auxiliary memory as table 02h when high |
| mem_rdata | input | 8 | Store read data, valid the cycle after `mem_rd` |
| mem_addr | output | 10 | Physical store address {page, offset} |
| mem_rd | output | 1 | Store read strobe |
| mem_wr | output | 1 | Store write strobe |
| mem_wdata | output | 8 | Store write data |
| no_loc | output | 1 | Current access targets a location that does not exist |
| table_num | output | 8 | Current table register value |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data returned to the front end |

## Verification
A read is answered in the cycle after its strobe, while the front end may already be writing a new table number at 7Fh. A late route decision would then return data from the wrong table or turn a void read into a store read. The bench provokes this with a read of a windowed byte, and also with a read of a void table, each followed directly by a write of the select register. The scoreboard then requires that the returned byte matches the table that was active when the read strobe was sampled. It also requires that the next windowed access already uses the new table.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int PAGE_W = 3;
    localparam int OFF_W  = ADDR_W - 1;
    localparam int PHYS_W = PAGE_W + OFF_W;

    typedef enum logic [2:0] {
        RG_IDLE,
        RG_LOW,
        RG_TSEL,
        RG_TABLE,
        RG_ALIAS,
        RG_AUXFLAT,
        RG_VOID
    } region_e;

    typedef struct packed {
        region_e           region;
        logic [PAGE_W-1:0] page;
    } route_t;

    typedef enum logic [1:0] {
        SRC_STORE,
        SRC_TSEL,
        SRC_VOID
    } rsrc_e;

    function automatic logic reaches_store(region_e r);
        return (r == RG_LOW) || (r == RG_TABLE) || (r == RG_ALIAS) || (r == RG_AUXFLAT);
    endfunction

    function automatic logic [ADDR_W-1:0] select_byte_addr();
        return {1'b0, {OFF_W{1'b1}}};
    endfunction

endpackage

// File: rtl/tpm_table_reg.sv
module tpm_table_reg
    import tpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] table_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            table_q <= '0;
        end else if (load) begin
            table_q <= din;
        end
    end

endmodule

// File: rtl/tpm_route_decode.sv
module tpm_route_decode
    import tpm_pkg::*;
#(
    parameter int NUM_TABLES  = 6,
    parameter int ALIAS_TABLE = 2,
    parameter int LOW_PAGE    = 6,
    parameter int AUX_PAGE    = 7
)(
    input  logic              active,
    input  logic              dev_aux,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] table_q,
    input  logic              aux_en,
    output route_t            route
);

    localparam logic [PAGE_W-1:0] LOW_PG = PAGE_W'(LOW_PAGE);
    localparam logic [PAGE_W-1:0] AUX_PG = PAGE_W'(AUX_PAGE);
    localparam logic [DATA_W-1:0] TBL_LIMIT = DATA_W'(NUM_TABLES);
    localparam logic [DATA_W-1:0] TBL_ALIAS = DATA_W'(ALIAS_TABLE);

    logic upper_half;
    logic is_select;

    assign upper_half = addr[ADDR_W-1];
    assign is_select  = (addr == select_byte_addr());

    always_comb begin
        route.region = RG_IDLE;
        route.page   = '0;
        if (active) begin
            if (dev_aux) begin
                if (upper_half) begin
                    route.region = RG_VOID;
                end else begin
                    route.region = RG_AUXFLAT;
                    route.page   = AUX_PG;
                end
            end else if (!upper_half) begin
                if (is_select) begin
                    route.region = RG_TSEL;
                end else begin
                    route.region = RG_LOW;
                    route.page   = LOW_PG;
                end
            end else if (table_q == TBL_ALIAS) begin
                if (aux_en) begin
                    route.region = RG_ALIAS;
                    route.page   = AUX_PG;
                end else begin
                    route.region = RG_VOID;
                end
            end else if (table_q < TBL_LIMIT) begin
                route.region = RG_TABLE;
                route.page   = table_q[PAGE_W-1:0];
            end else begin
                route.region = RG_VOID;
            end
        end
    end

endmodule

// File: rtl/tpm_read_return.sv
module tpm_read_return
    import tpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_fire,
    input  rsrc_e             src,
    input  logic [DATA_W-1:0] tsel_val,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic              valid_q;
    rsrc_e             src_q;
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            src_q   <= SRC_VOID;
            hold_q  <= '0;
        end else begin
            valid_q <= rd_fire;
            if (rd_fire) begin
                src_q  <= src;
                hold_q <= tsel_val;
            end
        end
    end

    always_comb begin
        unique case (src_q)
            SRC_STORE: rd_data = mem_rdata;
            SRC_TSEL:  rd_data = hold_q;
            default:   rd_data = '1;
        endcase
    end

    assign rd_valid = valid_q;

endmodule

// File: rtl/table_pager.sv
module table_pager
    import tpm_pkg::*;
#(
    parameter int NUM_TABLES  = 6,
    parameter int ALIAS_TABLE = 2,
    parameter int LOW_PAGE    = 6,
    parameter int AUX_PAGE    = 7
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_aux,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              aux_map_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PHYS_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              no_loc,
    output logic [DATA_W-1:0] table_num,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic   active;
    logic   rd_fire;
    logic   store_hit;
    logic   tsel_load;
    route_t route;
    rsrc_e  src;

    assign active  = rd_en | wr_en;
    assign rd_fire = rd_en & ~wr_en;

    tpm_route_decode #(
        .NUM_TABLES  (NUM_TABLES),
        .ALIAS_TABLE (ALIAS_TABLE),
        .LOW_PAGE    (LOW_PAGE),
        .AUX_PAGE    (AUX_PAGE)
    ) u_decode (
        .active  (active),
        .dev_aux (dev_aux),
        .addr    (addr),
        .table_q (table_num),
        .aux_en  (aux_map_en),
        .route   (route)
    );

    assign store_hit = reaches_store(route.region);
    assign tsel_load = wr_en & (route.region == RG_TSEL);

    tpm_table_reg u_table (
        .clk     (clk),
        .rst     (rst),
        .load    (tsel_load),
        .din     (wr_data),
        .table_q (table_num)
    );

    assign mem_addr  = {route.page, addr[OFF_W-1:0]};
    assign mem_rd    = rd_fire & store_hit;
    assign mem_wr    = wr_en & store_hit;
    assign mem_wdata = wr_data;
    assign no_loc    = (route.region == RG_VOID);

    always_comb begin
        if (store_hit)                     src = SRC_STORE;
        else if (route.region == RG_TSEL)  src = SRC_TSEL;
        else                               src = SRC_VOID;
    end

    tpm_read_return u_return (
        .clk       (clk),
        .rst       (rst),
        .rd_fire   (rd_fire),
        .src       (src),
        .tsel_val  (table_num),
        .mem_rdata (mem_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/table_pager_chk.sv
module table_pager_chk
    import tpm_pkg::*;
#(
    parameter int NUM_TABLES = 6,
    parameter int LOW_PAGE   = 6
)(
    input logic              clk,
    input logic              rst,
    input logic              dev_aux,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [PHYS_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              no_loc,
    input logic [DATA_W-1:0] table_num,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);

    logic sel_wr;
    assign sel_wr = wr_en && !dev_aux && (addr == select_byte_addr());

    // R1
    reset_table_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (table_num == '0));

    // R2
    low_half_page_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !dev_aux && !addr[ADDR_W-1] && addr != select_byte_addr())
        |-> (mem_rd && mem_addr[PHYS_W-1:OFF_W] == PAGE_W'(LOW_PAGE)));

    // R3
    select_load_chk: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> (table_num == $past(wr_data)));

    // R3
    select_no_store_chk: assert property (@(posedge clk) disable iff (rst)
        sel_wr |-> !mem_wr);

    // R7
    table_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_wr |=> $stable(table_num));

    // R6
    void_no_store_chk: assert property (@(posedge clk) disable iff (rst)
        no_loc |-> (!mem_rd && !mem_wr));

    // R6
    void_reads_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && no_loc) |=> (rd_data == '1));

    // R8
    read_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> rd_valid);

    // R8
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && !wr_en) |=> !rd_valid);

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !mem_rd);

endmodule

bind table_pager table_pager_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dev_aux   (dev_aux),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .no_loc    (no_loc),
    .table_num (table_num),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
);

// File: tb/table_pager_bench.sv
module table_pager_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dev_aux = 1'b0;
    logic [7:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       aux_map_en = 1'b0;
    logic [7:0] mem_rdata;
    logic [9:0] mem_addr;
    logic       mem_rd, mem_wr, no_loc, rd_valid;
    logic [7:0] mem_wdata, table_num, rd_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    table_pager u_table_pager (
        .clk(clk), .rst(rst), .dev_aux(dev_aux), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .aux_map_en(aux_map_en), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .no_loc(no_loc), .table_num(table_num),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // backing store with a registered read port
    logic [7:0] ram [1024];
    logic [7:0] ram_q;
    initial for (int i = 0; i < 1024; i++) ram[i] = 8'(i * 7 + 3);
    always @(posedge clk) begin
        if (mem_wr) ram[mem_addr] <= mem_wdata;
        if (mem_rd) ram_q <= ram[mem_addr];
    end
    assign mem_rdata = ram_q;

    // expected-state model kept by the bench
    logic [7:0] shadow [1024];
    logic [7:0] tbl_m = 8'h00;
    initial for (int i = 0; i < 1024; i++) shadow[i] = 8'(i * 7 + 3);

    typedef struct {
        logic [7:0] data;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // kind: 0 store, 1 select byte, 2 void
    function automatic void model(input logic aux, input logic [7:0] a,
                                  output int kind, output logic [9:0] phys);
        kind = 2;
        phys = '0;
        if (aux) begin
            if (!a[7]) begin kind = 0; phys = {3'd7, a[6:0]}; end
        end else if (!a[7]) begin
            if (a == 8'h7F) kind = 1;
            else begin kind = 0; phys = {3'd6, a[6:0]}; end
        end else if (tbl_m == 8'h02) begin
            if (aux_map_en) begin kind = 0; phys = {3'd7, a[6:0]}; end
        end else if (tbl_m < 8'h06) begin
            kind = 0; phys = {tbl_m[2:0], a[6:0]};
        end
    endfunction

    task automatic apply(input logic aux, input logic [7:0] a, input bit rd,
                         input bit wr, input logic [7:0] d, input string req);
        int kind;
        logic [9:0] phys;
        exp_t e;
        @(negedge clk);
        dev_aux = aux; addr = a; rd_en = rd; wr_en = wr; wr_data = d;
        #2;
        model(aux, a, kind, phys);
        check(no_loc == (kind == 2), req, "no_loc", no_loc, kind == 2);
        check(mem_wr == (wr && kind == 0), req, "mem_wr", mem_wr, wr && kind == 0);
        check(mem_rd == (rd && !wr && kind == 0), req, "mem_rd", mem_rd, rd && !wr && kind == 0);
        if (kind == 0) check(mem_addr == phys, req, "mem_addr", mem_addr, phys);
        if (wr) begin
            if (kind == 0) shadow[phys] = d;
            else if (kind == 1) tbl_m = d;
        end else if (rd) begin
            e.req  = req;
            e.data = (kind == 0) ? shadow[phys] : (kind == 1) ? tbl_m : 8'hFF;
            sb_q.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expected item per returned byte
    initial begin
        forever begin
            @(posedge clk);
            #15;
            if (!rst && rd_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected rd_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(rd_data == e.data, e.req, "rd_data", rd_data, e.data);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        check(1'b0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(table_num == 8'h00, "R1", "table_num after reset", table_num, 0);
        check(no_loc == 1'b0, "R1", "no_loc idle", no_loc, 0);
        check(rd_valid == 1'b0, "R1", "rd_valid idle", rd_valid, 0);

        // R2 fixed lower half
        apply(0, 8'h10, 0, 1, 8'hA5, "R2");
        apply(0, 8'h10, 1, 0, 8'h00, "R2");
        apply(0, 8'h7E, 1, 0, 8'h00, "R2");

        // R3 select register write and read back
        apply(0, 8'h7F, 0, 1, 8'h03, "R3");
        apply(0, 8'h7F, 1, 0, 8'h00, "R3");
        check(table_num == 8'h03, "R3", "table_num loaded", table_num, 3);

        // R4 windowed pages stay separate
        apply(0, 8'h85, 0, 1, 8'h3C, "R4");
        apply(0, 8'h7F, 0, 1, 8'h00, "R4");
        apply(0, 8'h85, 0, 1, 8'h77, "R4");
        apply(0, 8'h85, 1, 0, 8'h00, "R4");
        apply(0, 8'h10, 1, 0, 8'h00, "R2");
        apply(0, 8'h7F, 0, 1, 8'h05, "R4");
        apply(0, 8'hFF, 1, 0, 8'h00, "R4");
        apply(0, 8'h7F, 0, 1, 8'h01, "R4");
        apply(0, 8'h80, 0, 1, 8'h12, "R4");
        apply(0, 8'h80, 1, 0, 8'h00, "R4");

        // overlap: windowed read then select write in the next cycle
        apply(0, 8'h7F, 0, 1, 8'h03, "R4");
        apply(0, 8'h85, 1, 0, 8'h00, "R4");
        apply(0, 8'h7F, 0, 1, 8'h00, "R3");
        apply(0, 8'h85, 1, 0, 8'h00, "R4");

        // R6 alias table with mapping off
        aux_map_en = 1'b0;
        apply(0, 8'h7F, 0, 1, 8'h02, "R6");
        apply(0, 8'h90, 1, 0, 8'h00, "R6");
        apply(0, 8'h90, 0, 1, 8'h66, "R6");
        // void read then select write next cycle
        apply(0, 8'h90, 1, 0, 8'h00, "R6");
        apply(0, 8'h7F, 0, 1, 8'h02, "R6");

        // R5 alias table with mapping on
        idle(0);
        aux_map_en = 1'b1;
        apply(0, 8'h90, 0, 1, 8'h55, "R5");
        apply(0, 8'h90, 1, 0, 8'h00, "R5");

        // R7 auxiliary device
        apply(1, 8'h10, 1, 0, 8'h00, "R7");
        apply(1, 8'h7F, 0, 1, 8'hEE, "R7");
        apply(0, 8'hFF, 1, 0, 8'h00, "R7");
        check(table_num == 8'h02, "R7", "table unchanged by aux 7F", table_num, 2);
        apply(1, 8'h90, 1, 0, 8'h00, "R7");
        apply(1, 8'hC0, 0, 1, 8'h99, "R7");
        apply(1, 8'h40, 1, 0, 8'h00, "R7");

        // R6 table numbers beyond the last table
        apply(0, 8'h7F, 0, 1, 8'h06, "R6");
        apply(0, 8'hA0, 1, 0, 8'h00, "R6");
        apply(0, 8'h7F, 0, 1, 8'hFF, "R6");
        apply(0, 8'hA0, 0, 1, 8'h44, "R6");
        apply(0, 8'hA0, 1, 0, 8'h00, "R6");
        apply(0, 8'h7F, 1, 0, 8'h00, "R3");

        // R9 both strobes: write only, no returned byte
        apply(0, 8'h20, 1, 1, 8'h99, "R9");
        apply(0, 8'h20, 1, 0, 8'h00, "R9");
        apply(0, 8'h7F, 1, 1, 8'h04, "R9");
        apply(0, 8'hC3, 1, 0, 8'h00, "R9");

        // R8 back-to-back reads then quiet
        apply(0, 8'h01, 1, 0, 8'h00, "R8");
        apply(0, 8'h02, 1, 0, 8'h00, "R8");
        apply(0, 8'h03, 1, 0, 8'h00, "R8");
        idle(4);
        check(sb_q.size() == 0, "R8", "reads left unanswered", sb_q.size(), 0);
        finish_run();
    end

endmodule